// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block writes one byte into a one-time-programmable parallel memory. Every cell of the memory starts at 1, and programming can only turn a cell to 0. A host presents an address and a data byte and gives a one-cycle start strobe. The block then drives the memory's address lines, the data bus, an active-low chip-enable and an active-low output-enable. It repeats a cycle of timed program pulse and read-back until the byte reads correctly or the pulse budget runs out.

The block first reads the addressed byte. Some requested 1 bits may sit over stored 0 bits, which no pulse can fix, and in that case the block fails at once without pulsing. If the byte already holds the requested value, the block succeeds with zero pulses. Otherwise each round has four steps:

- a setup interval, with address and data driven;
- a chip-enable pulse of fixed length in microseconds;
- a hold interval;
- a verify read, with the bus released.

The sequence stops at the first verify that matches. A programming-voltage enable output stays high for the whole sequence. The memory data bus is modelled as a separate input, a separate output and a drive enable.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset the block is idle. `mem_ce_no` and `mem_oe_no` are 1, and `mem_data_oe_o`, `vpp_en_o`, `busy_o` and `done_o` are 0.
- R2: A start strobe seen while idle captures `addr_i` and `data_i`. `busy_o` and `vpp_en_o` are 1 from the next cycle up to and including the done cycle, and are 0 afterwards.
- R3: The first step is a read of `READ_CYC` cycles with `mem_ce_no`=1, `mem_oe_no`=0 and the bus released. If any requested 1 bit sits over a stored 0 bit, the sequence ends right after this read with failure and a pulse count of 0, and no chip-enable pulse is issued.
- R4: If the pre-check read already equals the requested byte, the sequence ends right after it with success and a pulse count of 0.
- R5: Each round drives the captured address and data for `SETUP_CYC` cycles, then holds `mem_ce_no` low for CLK_HZ/1000*PULSE_US/1000 cycles, then keeps driving for `HOLD_CYC` cycles. `mem_oe_no` stays 1 throughout, and address and data do not change.
- R6: After each hold interval, a verify read of `READ_CYC` cycles is made with `mem_ce_no`=1, `mem_oe_no`=0 and the bus released. A match ends the sequence with success, and the pulse count equals the number of pulses issued.
- R7: If the verify after pulse number `MAX_PULSES` still mismatches, the sequence ends with failure and a pulse count of `MAX_PULSES`. No pulse beyond that number is issued.
- R8: A start strobe that arrives while `busy_o` is 1 is ignored. The timing, the target address and the data of the running sequence are unchanged, and no other address is written.
- R9: `done_o` is a one-cycle pulse in the last busy cycle. `fail_o` (1 means failure) and `pulse_cnt_o` are valid in that cycle and hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to program a byte |
| addr_i | input | ADDR_W | Target address |
| data_i | input | DATA_W | Byte to program |
| mem_data_i | input | DATA_W | Data bus as driven by the memory |
| mem_addr_o | output | ADDR_W | Memory address lines |
| mem_data_o | output | DATA_W | Data driven toward the memory |
| mem_data_oe_o | output | 1 | 1 when the block drives the data bus |
| mem_ce_no | output | 1 | Chip-enable, active low (program pulse) |
| mem_oe_no | output | 1 | Output-enable, active low (read) |
| vpp_en_o | output | 1 | Programming-voltage enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Result of the last sequence, 1 means failure |
| pulse_cnt_o | output | $clog2(MAX_PULSES+1) | Pulses used by the last sequence |

## Verification
The bench builds the block with CLK_HZ=200000 and PULSE_US=100, which gives a 20-cycle pulse. It uses SETUP_CYC=3, HOLD_CYC=2, READ_CYC=2, MAX_PULSES=10 and a 4-bit address. With these values a full ten-pulse failure takes under 300 cycles, so cases that need exactly ten pulses (success on the last allowed pulse) and eleven pulses (failure at the budget) both fit in one short run. The bench also covers the two zero-pulse exits and a mid-sequence start strobe. Its memory model clears bits only after a chosen number of pulses.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECHK,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_VERIFY,
    ST_FIN
  } prog_state_e;
endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] len_i,
  output logic             expired_o
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (load_i)            tmr_q <= len_i - TMR_W'(1);
    else if (tmr_q != '0)       tmr_q <= tmr_q - TMR_W'(1);
  end

  assign expired_o = (tmr_q == '0);
endmodule

// File: rtl/prog_bitcheck.sv
module prog_bitcheck #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] req_i,
  input  logic [DATA_W-1:0] rd_i,
  output logic              match_o,
  output logic              blocked_o
);
  logic [DATA_W-1:0] blk, diff;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign blk[b]  = req_i[b] & ~rd_i[b];  // wants 1, cell already 0
    assign diff[b] = req_i[b] ^ rd_i[b];
  end

  assign match_o   = (diff == '0);
  assign blocked_o = |blk;
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 10,
  parameter int SETUP_CYC  = 4,
  parameter int HOLD_CYC   = 4,
  parameter int READ_CYC   = 3,
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_data_oe_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              vpp_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  pulse_cnt_o
);
  localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;
  localparam int TMR_W     = $clog2(PULSE_CYC + SETUP_CYC + HOLD_CYC + READ_CYC + 1);
  localparam logic [TMR_W-1:0] L_PULSE = TMR_W'(PULSE_CYC);
  localparam logic [TMR_W-1:0] L_SETUP = TMR_W'(SETUP_CYC);
  localparam logic [TMR_W-1:0] L_HOLD  = TMR_W'(HOLD_CYC);
  localparam logic [TMR_W-1:0] L_READ  = TMR_W'(READ_CYC);
  localparam logic [TMR_W-1:0] L_ONE   = TMR_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PULSES);

  prog_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              fail_q, fail_d;
  logic              tmr_exp, rd_match, rd_blocked;
  logic [TMR_W-1:0]  len_d;

  prog_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_d != state_q),
    .len_i     (len_d),
    .expired_o (tmr_exp)
  );

  prog_bitcheck #(.DATA_W(DATA_W)) u_check (
    .req_i     (data_q),
    .rd_i      (mem_data_i),
    .match_o   (rd_match),
    .blocked_o (rd_blocked)
  );

  always_comb begin
    state_d = state_q;
    fail_d  = fail_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_PRECHK;
      ST_PRECHK: if (tmr_exp) begin
        if (rd_blocked)    begin state_d = ST_FIN; fail_d = 1'b1; end
        else if (rd_match) begin state_d = ST_FIN; fail_d = 1'b0; end
        else                     state_d = ST_SETUP;
      end
      ST_SETUP:  if (tmr_exp) state_d = ST_PULSE;
      ST_PULSE:  if (tmr_exp) state_d = ST_HOLD;
      ST_HOLD:   if (tmr_exp) state_d = ST_VERIFY;
      ST_VERIFY: if (tmr_exp) begin
        if (rd_match)              begin state_d = ST_FIN; fail_d = 1'b0; end
        else if (cnt_q == CNT_MAX) begin state_d = ST_FIN; fail_d = 1'b1; end
        else                             state_d = ST_SETUP;
      end
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_PRECHK, ST_VERIFY: len_d = L_READ;
      ST_SETUP:             len_d = L_SETUP;
      ST_PULSE:             len_d = L_PULSE;
      ST_HOLD:              len_d = L_HOLD;
      default:              len_d = L_ONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        addr_q <= addr_i;
        data_q <= data_i;
        cnt_q  <= '0;
        fail_q <= 1'b0;
      end else begin
        fail_q <= fail_d;
        if (state_q == ST_SETUP && state_d == ST_PULSE) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign mem_addr_o    = addr_q;
  assign mem_data_o    = data_q;
  assign mem_data_oe_o = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign mem_ce_no     = (state_q != ST_PULSE);
  assign mem_oe_no     = !((state_q == ST_PRECHK) || (state_q == ST_VERIFY));
  assign busy_o        = (state_q != ST_IDLE);
  assign vpp_en_o      = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_FIN);
  assign fail_o        = fail_q;
  assign pulse_cnt_o   = cnt_q;

  // Assertion support: length of the current chip-enable low run
  logic [TMR_W-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         low_run_q <= '0;
    else if (!mem_ce_no) low_run_q <= low_run_q + TMR_W'(1);
    else                 low_run_q <= '0;
  end

  AST_PULSE_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> (mem_oe_no && mem_data_oe_o));  // R5
  AST_SETUP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> ($past(mem_data_oe_o) && $stable(mem_addr_o) && $stable(mem_data_o)));  // R5
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> (mem_data_oe_o && $stable(mem_addr_o) && $stable(mem_data_o)));  // R5
  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> (low_run_q == L_PULSE));  // R5
  AST_READ_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (mem_ce_no && !mem_data_oe_o));  // R6
  AST_PULSE_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> (pulse_cnt_o <= CNT_MAX && pulse_cnt_o != '0));  // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o && !vpp_en_o));  // R9
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(done_o) && $past(!busy_o)) |-> ($stable(fail_o) && $stable(pulse_cnt_o)));  // R9
  AST_CAPTURE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(mem_addr_o) && $stable(mem_data_o)));  // R8
endmodule

// File: tb/eprom_prog_seq_bench.sv
module eprom_prog_seq_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int MAXP   = 10;
  localparam int RC = 2, SC = 3, WC = 20, HC = 2;
  localparam int PER = SC + WC + HC + RC;
  localparam int CNT_W = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data = '0;
  logic [DATA_W-1:0] mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wd;
  logic mem_doe, ce_n, oe_n, vpp, busy, done, fail;
  logic [CNT_W-1:0] pcnt;

  int n_chk = 0, n_fail = 0;
  logic [DATA_W-1:0] mem [16];
  int need = 1, seen = 0;
  bit model_on = 1'b0;

  always #10 clk = ~clk;

  eprom_prog_seq #(
    .CLK_HZ(200_000), .PULSE_US(100), .MAX_PULSES(MAXP),
    .SETUP_CYC(SC), .HOLD_CYC(HC), .READ_CYC(RC),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_eprom_prog_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .data_i(data),
    .mem_data_i(mem_rd), .mem_addr_o(mem_addr), .mem_data_o(mem_wd),
    .mem_data_oe_o(mem_doe), .mem_ce_no(ce_n), .mem_oe_no(oe_n),
    .vpp_en_o(vpp), .busy_o(busy), .done_o(done), .fail_o(fail), .pulse_cnt_o(pcnt)
  );

  // Behavioural memory: bits clear only once 'need' pulses have been applied
  assign mem_rd = (!oe_n && ce_n) ? mem[mem_addr] : 8'hFF;
  always @(posedge ce_n) begin
    if (model_on) begin
      seen++;
      if (seen >= need) mem[mem_addr] = mem[mem_addr] & mem_wd;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_cycle(input int t, input int fin, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, input int n, input bit f);
    bit e_ce = 1, e_oe = 1, e_doe = 0, ok;
    bit e_busy = (t <= fin);
    if (t < RC) e_oe = 0;
    else if (t < fin) begin
      int k = (t - RC) % PER;
      if (k < SC) e_doe = 1;
      else if (k < SC + WC) begin e_doe = 1; e_ce = 0; end
      else if (k < SC + WC + HC) e_doe = 1;
      else e_oe = 0;
    end
    ok = (ce_n == e_ce) && (oe_n == e_oe) && (mem_doe == e_doe) && (busy == e_busy)
         && (vpp == e_busy) && (done == (t == fin));
    if (e_busy) ok = ok && (mem_addr == a) && (mem_wd == d);
    if (t >= fin) ok = ok && (fail == f) && (pcnt == CNT_W'(n));
    check(ok, (e_ce == 0 || e_doe) ? "R5" : (t >= fin ? "R9" : "R6"),
          $sformatf("t=%0d ce/oe/doe/busy/vpp/done/fail/cnt", t),
          {ce_n, oe_n, mem_doe, busy, vpp, done, fail, 4'(pcnt)},
          {e_ce, e_oe, e_doe, e_busy, e_busy, (t == fin), (t >= fin) ? f : fail,
           (t >= fin) ? 4'(n) : 4'(pcnt)});
  endtask

  // One programming request with the reference outcome worked out up front
  task automatic run_op(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] stored,
                        input logic [DATA_W-1:0] d, input int nd, input bit stray,
                        input string req);
    int n; bit f; int fin; logic [DATA_W-1:0] e_mem;
    logic [ADDR_W-1:0] other = a + 4'd1;
    logic [DATA_W-1:0] other_v;
    mem[a] = stored; need = nd; seen = 0;
    other_v = mem[other];
    if ((d & ~stored) != 0)  begin n = 0; f = 1; e_mem = stored; end
    else if (d == stored)    begin n = 0; f = 0; e_mem = stored; end
    else if (nd <= MAXP)     begin n = nd; f = 0; e_mem = d; end
    else                     begin n = MAXP; f = 1; e_mem = stored; end
    fin = RC + n * PER;
    addr = a; data = d; start = 1'b1;
    @(posedge clk); #5;
    start = 1'b0;
    for (int t = 0; t <= fin + 3; t++) begin
      cmp_cycle(t, fin, a, d, n, f);
      if (stray && t == 3) begin start = 1'b1; addr = other; data = 8'h00; end
      @(posedge clk); #5;
      start = 1'b0; addr = a; data = d;
    end
    check(mem[a] == e_mem, req, "final byte", mem[a], e_mem);
    check(pcnt == CNT_W'(n) && fail == f, req, "result cnt/fail", {pcnt, 3'b0, fail}, {4'(n), 3'b0, f});
    if (stray) check(mem[other] == other_v, "R8", "stray-start address untouched", mem[other], other_v);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog: actual still running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    #35;
    check(ce_n && oe_n && !mem_doe && !vpp && !busy && !done, "R1", "reset outputs",
          {ce_n, oe_n, mem_doe, vpp, busy, done}, 6'b110000);
    rst_n = 1'b1;
    @(posedge clk); #5;
    model_on = 1'b1;
    check(ce_n && oe_n && !busy && !vpp, "R1", "idle after reset", {ce_n, oe_n, busy, vpp}, 4'b1100);
    run_op(4'd2, 8'h0F, 8'hF0, 1, 1'b0, "R3");   // unreachable bits: fail, no pulse
    run_op(4'd3, 8'hA5, 8'hA5, 1, 1'b0, "R4");   // already programmed
    run_op(4'd4, 8'hFF, 8'h3C, 1, 1'b0, "R6");   // one pulse suffices
    run_op(4'd5, 8'hFF, 8'h00, 4, 1'b1, "R8");   // stray start mid-sequence
    run_op(4'd7, 8'hFF, 8'h81, 10, 1'b0, "R7");  // succeeds on last allowed pulse
    run_op(4'd8, 8'hFF, 8'h55, 11, 1'b0, "R7");  // budget exhausted
    run_op(4'd9, 8'hF0, 8'h30, 3, 1'b0, "R2");   // partially programmed cell
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule